// File: doc/BRIEF.md
# Interrupt Status and Mask Register Bank

This block holds the interrupt state of a serial peripheral controller. It has seven interrupt lines. All four of its registers use the same bit layout: a raw pending register, an enable strobe register, a disable strobe register and a mask readback register.

- Hardware sources pulse `evt_i` and set pending bits, which stay set until cleared.
- Software clears a pending bit by writing 1 to it.
- Software never writes the mask directly. It writes 1s to the enable strobe to turn mask bits on, and 1s to the disable strobe to turn them off. It reads the resulting mask back through its own register.
- A single registered interrupt line, `irq_o`, reports whether any pending bit is also enabled.

Within the seven-bit layout the sources assign bit 1 to a mode fault, bit 2 to the transmit queue rising above its watermark, bit 3 to the transmit queue being full and bit 4 to the receive queue holding data. The block itself treats all seven bits alike.

Access uses a plain single-cycle port. A write happens on the clock edge where `wr_en_i` is high. Read data is combinational from `addr_i`. The reset input is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `irq_regbank`

## Requirements
- R1: While reset is asserted, and directly after it, every pending bit and every mask bit is 0 and `irq_o` is 0.
- R2: A 1 on `evt_i[i]` in a cycle makes pending bit i read as 1 after that clock edge. The bit stays 1 after the pulse ends, until it is cleared.
- R3: A write to the pending register (offset 0x04) clears every pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event and a clearing write hit the same pending bit in the same cycle, the bit reads 1 afterwards.
- R5: A write to the enable strobe (offset 0x08) sets each mask bit whose write-data bit is 1. Write-data bits of 0, and write-data bits above bit 6, change nothing.
- R6: A write to the disable strobe (offset 0x0C) clears each mask bit whose write-data bit is 1. Bits written with 0 keep their value.
- R7: Reading offset 0x04 returns the pending bits in data bits 6:0. Reading offset 0x10 returns the mask bits in data bits 6:0. All other data bits read 0. Reads of offsets 0x08 and 0x0C, and of any unmapped offset, return 0.
- R8: `irq_o` is a register. Its value after a clock edge equals the OR of (pending AND mask) as it stood before that edge.
- R9: Writes to any offset other than 0x04, 0x08 and 0x0C change neither the pending bits nor the mask. Writes to the mask readback offset 0x10 are among these.
- R10: An event sets its pending bit whether or not the matching mask bit is set. Enable and disable writes leave the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_IRQ (7) | Interrupt event pulses, one per bit |
| wr_en_i | input | 1 | Write strobe, acts on the rising clock edge |
| addr_i | input | ADDR_W (8) | Byte offset for both reads and writes |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench aims first at a collision between an event and a clearing write on the same bit. A design that let the clear win would drop an interrupt that arrived while software was acknowledging the previous one.

It writes zero-valued bits and upper data bits to each strobe register and to the pending register. A design that treated those writes as plain stores would wipe the mask or clear pending bits that were never acknowledged.

It reads both write-only offsets and writes to the mask readback offset. This catches a decoder that aliases the strobes onto the mask, or that lets the readback offset be written.

It also checks `irq_o` exactly one cycle after each change to the pending bits or the mask. A design that made the line combinational, or that registered it twice, would be off by one cycle.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

  // Bit roles inside the shared seven-bit layout.
  localparam int unsigned IRQ_BIT_MODE_FAULT = 1;
  localparam int unsigned IRQ_BIT_TX_WATER   = 2;
  localparam int unsigned IRQ_BIT_TX_FULL    = 3;
  localparam int unsigned IRQ_BIT_RX_AVAIL   = 4;

  // Default byte offsets of the four registers.
  localparam int unsigned OFS_PEND_DEF = 32'h04;
  localparam int unsigned OFS_SET_DEF  = 32'h08;
  localparam int unsigned OFS_CLR_DEF  = 32'h0C;
  localparam int unsigned OFS_MASK_DEF = 32'h10;

  // One-hot register hit vector from the decoder.
  typedef struct packed {
    logic pend;
    logic set;
    logic clr;
    logic mask;
  } reg_hit_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFS_PEND = OFS_PEND_DEF,
  parameter int unsigned OFS_SET  = OFS_SET_DEF,
  parameter int unsigned OFS_CLR  = OFS_CLR_DEF,
  parameter int unsigned OFS_MASK = OFS_MASK_DEF
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output reg_hit_t          rd_hit_o,
  output reg_hit_t          wr_hit_o
);

  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  always_comb begin
    rd_hit_o.pend = (addr_i == A_PEND);
    rd_hit_o.set  = (addr_i == A_SET);
    rd_hit_o.clr  = (addr_i == A_CLR);
    rd_hit_o.mask = (addr_i == A_MASK);
  end

  // The mask readback offset is read-only: it never yields a write hit.
  always_comb begin
    wr_hit_o.pend = wr_en_i & rd_hit_o.pend;
    wr_hit_o.set  = wr_en_i & rd_hit_o.set;
    wr_hit_o.clr  = wr_en_i & rd_hit_o.clr;
    wr_hit_o.mask = 1'b0;
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               clr_sel_i,
  input  logic [NUM_IRQ-1:0] clr_bits_i,
  output logic [NUM_IRQ-1:0] pend_q
);

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    logic clr_hit;
    logic bit_ce;
    logic bit_nxt;

    assign clr_hit = clr_sel_i & clr_bits_i[b];

    // The event takes priority over a clear in the same cycle.
    always_comb begin
      bit_ce  = evt_i[b] | clr_hit;
      bit_nxt = pend_q[b];
      if (evt_i[b]) begin
        bit_nxt = 1'b1;
      end else if (clr_hit) begin
        bit_nxt = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b] <= 1'b0;
      end else if (bit_ce) begin
        pend_q[b] <= bit_nxt;
      end
    end
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_sel_i,
  input  logic               clr_sel_i,
  input  logic [NUM_IRQ-1:0] bits_i,
  output logic [NUM_IRQ-1:0] mask_q
);

  for (genvar b = 0; b < NUM_IRQ; b++) begin : g_bit
    logic bit_ce;
    logic bit_nxt;

    always_comb begin
      bit_ce  = (set_sel_i | clr_sel_i) & bits_i[b];
      bit_nxt = mask_q[b];
      if (set_sel_i) begin
        bit_nxt = 1'b1;
      end else if (clr_sel_i) begin
        bit_nxt = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b] <= 1'b0;
      end else if (bit_ce) begin
        mask_q[b] <= bit_nxt;
      end
    end
  end

endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg #(
  parameter int unsigned NUM_IRQ = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic               irq_o
);

  logic line_nxt;
  logic line_q;

  always_comb begin
    line_nxt = |(pend_i & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else begin
      line_q <= line_nxt;
    end
  end

  assign irq_o = line_q;

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 7,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFS_PEND = OFS_PEND_DEF,
  parameter int unsigned OFS_SET  = OFS_SET_DEF,
  parameter int unsigned OFS_CLR  = OFS_CLR_DEF,
  parameter int unsigned OFS_MASK = OFS_MASK_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);

  reg_hit_t           rd_hit;
  reg_hit_t           wr_hit;
  logic [NUM_IRQ-1:0] wr_bits;
  logic [NUM_IRQ-1:0] sts_q;
  logic [NUM_IRQ-1:0] msk_q;
  logic               unused_wdata_hi;

  assign wr_bits         = wdata_i[NUM_IRQ-1:0];
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_IRQ];

  irq_reg_decode #(
    .ADDR_W   (ADDR_W),
    .OFS_PEND (OFS_PEND),
    .OFS_SET  (OFS_SET),
    .OFS_CLR  (OFS_CLR),
    .OFS_MASK (OFS_MASK)
  ) u_dec (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit)
  );

  irq_pend_bank #(
    .NUM_IRQ (NUM_IRQ)
  ) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .clr_sel_i  (wr_hit.pend),
    .clr_bits_i (wr_bits),
    .pend_q     (sts_q)
  );

  irq_mask_bank #(
    .NUM_IRQ (NUM_IRQ)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_sel_i (wr_hit.set),
    .clr_sel_i (wr_hit.clr),
    .bits_i    (wr_bits),
    .mask_q    (msk_q)
  );

  irq_line_reg #(
    .NUM_IRQ (NUM_IRQ)
  ) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (sts_q),
    .mask_i (msk_q),
    .irq_o  (irq_o)
  );

  // Read mux. The strobe offsets and unmapped offsets read as zero.
  always_comb begin
    rdata_o = '0;
    if (rd_hit.pend) begin
      rdata_o[NUM_IRQ-1:0] = sts_q;
    end else if (rd_hit.mask) begin
      rdata_o[NUM_IRQ-1:0] = msk_q;
    end
  end

endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
  parameter int unsigned NUM_IRQ  = 7,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFS_PEND = 32'h04,
  parameter int unsigned OFS_SET  = 32'h08,
  parameter int unsigned OFS_CLR  = 32'h0C
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] evt_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_IRQ-1:0] sts_q,
  input logic [NUM_IRQ-1:0] msk_q
);

  logic pend_wr;
  logic mask_wr;
  logic strobe_rd;

  assign pend_wr   = wr_en_i && (addr_i == ADDR_W'(OFS_PEND));
  assign mask_wr   = wr_en_i && ((addr_i == ADDR_W'(OFS_SET)) || (addr_i == ADDR_W'(OFS_CLR)));
  assign strobe_rd = (addr_i == ADDR_W'(OFS_SET)) || (addr_i == ADDR_W'(OFS_CLR));

  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R3

  AST_PEND_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|evt_i) |=> ((sts_q & ~$past(sts_q)) == '0)); // R10

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(msk_q)); // R9

  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rd |-> (rdata_o == '0)); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_o == $past(|(sts_q & msk_q)))); // R8

endmodule

bind irq_regbank irq_regbank_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .OFS_PEND (OFS_PEND),
  .OFS_SET  (OFS_SET),
  .OFS_CLR  (OFS_CLR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_i   (evt_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .sts_q   (sts_q),
  .msk_q   (msk_q)
);

// File: tb/irq_regbank_tb_top.sv
module irq_regbank_tb_top;

  localparam int unsigned NIRQ = 7;
  localparam int unsigned AW   = 8;
  localparam int unsigned DW   = 32;

  localparam logic [AW-1:0] A_PEND = 8'h04;
  localparam logic [AW-1:0] A_SET  = 8'h08;
  localparam logic [AW-1:0] A_CLR  = 8'h0C;
  localparam logic [AW-1:0] A_MASK = 8'h10;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] rd_exp;
    logic          irq_exp;
    string         tag;
  } sb_item_t;

  logic            clk;
  logic            rst_n;
  logic [NIRQ-1:0] evt_i;
  logic            wr_en_i;
  logic [AW-1:0]   addr_i;
  logic [DW-1:0]   wdata_i;
  logic [DW-1:0]   rdata_o;
  logic            irq_o;

  sb_item_t        sb_q[$];
  logic [NIRQ-1:0] m_sts;
  logic [NIRQ-1:0] m_msk;
  int              n_chk;
  int              n_fail;
  bit              done;

  irq_regbank dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    if (a == A_PEND) v[NIRQ-1:0] = m_sts;
    else if (a == A_MASK) v[NIRQ-1:0] = m_msk;
    return v;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic cyc(input logic [NIRQ-1:0] evt, input logic wr,
                     input logic [AW-1:0] a, input logic [DW-1:0] wd,
                     input string tag);
    sb_item_t it;
    @(negedge clk);
    evt_i   = evt;
    wr_en_i = wr;
    addr_i  = a;
    wdata_i = wd;
    it.irq_exp = |(m_sts & m_msk);
    if (rst_n) begin
      if (wr && a == A_PEND) m_sts = m_sts & ~wd[NIRQ-1:0];
      m_sts = m_sts | evt;
      if (wr && a == A_SET) m_msk = m_msk | wd[NIRQ-1:0];
      if (wr && a == A_CLR) m_msk = m_msk & ~wd[NIRQ-1:0];
    end
    it.addr   = a;
    it.rd_exp = model_rd(a);
    it.tag    = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc('0, 1'b0, a, '0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
    cyc('0, 1'b1, a, wd, tag);
  endtask

  // Monitor: checks queued items 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (rdata_o !== it.rd_exp) begin
          n_fail++;
          $display("FAIL %s rdata addr=%h actual=%h expected=%h", it.tag, it.addr, rdata_o, it.rd_exp);
        end
        n_chk++;
        if (irq_o !== it.irq_exp) begin
          n_fail++;
          $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq_o, it.irq_exp);
        end
      end
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    m_sts = '0; m_msk = '0;
    rst_n = 1'b0; evt_i = '0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    // R1: reset state, during reset and directly after it.
    rd(A_PEND, "R1 pend in reset");
    rd(A_MASK, "R1 mask in reset");
    @(negedge clk);
    rst_n = 1'b1;
    rd(A_PEND, "R1 pend after reset");
    rd(A_MASK, "R1 mask after reset");
    // R2: event sets a bit that stays set; R10: while masked.
    cyc(7'h02, 1'b0, A_PEND, '0, "R2 R10 event sets bit1");
    rd(A_PEND, "R2 bit1 sticky");
    // R5: enable write, zero and upper bits ignored.
    wr(A_SET, 32'hFFFF_FF80, "R5 upper bits no effect");
    rd(A_MASK, "R5 mask unchanged");
    wr(A_SET, 32'h0000_0006, "R5 enable bits 1,2");
    rd(A_PEND, "R8 irq after enable, R10 pend unchanged");
    wr(A_SET, 32'h0000_0000, "R5 zero write");
    // R7: strobe offsets and unmapped offsets read zero.
    rd(A_SET, "R7 enable reads zero");
    rd(A_CLR, "R7 disable reads zero");
    rd(8'h00, "R7 unmapped reads zero");
    rd(8'h14, "R7 unmapped reads zero");
    // R9: writes to readback and unmapped offsets change nothing.
    wr(A_MASK, 32'h0000_007F, "R9 mask offset not writable");
    wr(8'h14, 32'h0000_007F, "R9 unmapped write");
    wr(8'h00, 32'h0000_007F, "R9 unmapped write");
    rd(A_PEND, "R9 pend unchanged");
    // R3: write-one-to-clear, zeros no effect.
    wr(A_PEND, 32'h0000_0000, "R3 zero write keeps bits");
    wr(A_PEND, 32'h0000_0004, "R3 clear of idle bit");
    wr(A_PEND, 32'h0000_0002, "R3 clear bit1");
    rd(A_PEND, "R8 irq drops after clear");
    rd(A_PEND, "R8 irq low");
    // R4: set wins over a clear in the same cycle.
    cyc(7'h10, 1'b1, A_PEND, 32'h0000_0010, "R4 set wins");
    rd(A_PEND, "R4 bit4 still set");
    // R10: masked events still set pending bits.
    cyc(7'h40, 1'b0, A_MASK, '0, "R10 masked event sets bit6");
    rd(A_PEND, "R10 irq stays low");
    // R6: disable writes.
    wr(A_CLR, 32'h0000_0000, "R6 zero write keeps mask");
    wr(A_SET, 32'h0000_0040, "R5 enable bit6");
    rd(A_PEND, "R8 irq rises via bit6");
    wr(A_CLR, 32'h0000_0044, "R6 disable bits 2,6");
    rd(A_MASK, "R6 mask after disable");
    rd(A_PEND, "R8 irq low after disable");
    // Sweep every bit: event, enable, clear.
    for (int i = 0; i < NIRQ; i++) begin
      wr(A_PEND, 32'h0000_007F, "R3 clear all");
      wr(A_CLR, 32'h0000_007F, "R6 disable all");
      cyc(7'(1 << i), 1'b0, A_PEND, '0, "R2 sweep event");
      wr(A_SET, 32'(1 << i), "R5 sweep enable");
      rd(A_MASK, "R8 sweep irq high");
      cyc(7'(1 << ((i + 1) % NIRQ)), 1'b1, A_PEND, 32'(1 << i), "R3 R4 sweep clear other set");
      rd(A_PEND, "R8 sweep irq low");
    end
    rd(A_PEND, "R2 final");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
  end

endmodule